// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the processor reset lines of a supply supervisor. Two conditions request reset: a supply-low flag that an external comparator has already turned into a digital level, and an active-low manual request from a push button, a logic output or a watchdog output wired back into it. Reset is held for as long as either condition is present. Once both have cleared, it is held for a further fixed stretch. The length of that stretch is counted in tick-enable pulses and is set by a parameter. With a 1 kHz tick, the default of 200 ticks gives the nominal 200 ms. Any value between 160 and 280 ticks at that rate stays within the allowed window.

One retriggerable counter sets the stretch for both sources. The same counter also debounces the manual input: any bounce restarts the count, so a noisy button only lengthens the assertion. The manual input is first passed through a two-flop synchronizer. The block has no watchdog input. A watchdog can reset the processor only through an external connection to the manual input. Two outputs are provided, one active low and one active high, and the active-high output is always the inverse of the active-low one.

Top module: `sup_reset_pulse_gen`

## Requirements
- R1: While rst_ni is low, rst_no is 0 and rst_o is 1.
- R2: After rst_ni rises with no request pending, reset stays asserted for STRETCH_TICKS to STRETCH_TICKS+1 ticks of tick_i, then releases.
- R3: supply_low_i high at a clock edge makes rst_no 0 after that edge, and rst_no stays 0 for every cycle the flag remains high.
- R4: After supply_low_i falls, rst_no stays 0 until the stretch counter has consumed STRETCH_TICKS ticks. It rises on the first clock edge at which the counter is already zero and neither source is active, which is STRETCH_TICKS or STRETCH_TICKS+1 ticks after the flag fell.
- R5: A low level on man_rst_ni makes rst_no 0 exactly three clock edges later: two synchronizer stages plus the output register.
- R6: After man_rst_ni returns high, reset stays asserted for the full stretch, which is STRETCH_TICKS to STRETCH_TICKS+2 ticks, counted from the rising input.
- R7: A low pulse on man_rst_ni, even one lasting a single cycle, seen while the stretch is running reloads the counter. No release pulse appears during the bounce, and the stretch restarts from the last low sample.
- R8: rst_o equals the inverse of rst_no on every cycle.
- R9: Clock cycles with tick_i low do not advance the stretch. Reset stays asserted however many cycles pass without a tick.
- R10: When both sources are active and one clears, reset stays asserted until the other also clears. The full stretch then runs from the later release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Time-base enable; one pulse per stretch unit |
| supply_low_i | input | 1 | Digitized supply-below-threshold flag, synchronous to clk_i |
| man_rst_ni | input | 1 | Asynchronous active-low manual reset request |
| rst_no | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset, complement of rst_no |

## Verification
A reload and a release can fall on the same clock edge. This happens when the counter reaches zero in the cycle where a manual bounce or a new supply-low sample arrives. It also happens when one source clears in the same cycle that the other is still active. The bench provokes these cases with single-cycle manual pulses injected while the stretch is running, with both sources asserted and then released in turn, and with the tick frozen just as the supply flag drops. A behavioural model built from a delay queue and a remaining-ticks integer decides the expected level on every clock. The bench flags any cycle where a release pulse escapes while a reload is pending.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  typedef struct packed {
    logic supply_low;
    logic man_low;
  } rst_req_t;

  function automatic logic any_req(rst_req_t r);
    return r.supply_low | r.man_low;
  endfunction
endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch #(
  parameter int TICKS = 200,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);

  logic [CNT_W-1:0] cnt_q;

  // reload dominates; power-up starts a full stretch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= FULL;
    else if (reload_i)                  cnt_q <= FULL;
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  // R9
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !tick_i) |=> $stable(cnt_q));

  // R7
  no_climb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/sup_rst_out.sv
module sup_rst_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic done_i,
  output logic rst_no,
  output logic rst_o
);
  logic nxt_asserted;
  logic low_q, high_q;

  always_comb begin
    nxt_asserted = high_q;
    if (reload_i)    nxt_asserted = 1'b1;
    else if (done_i) nxt_asserted = 1'b0;
  end

  // separate flops per polarity, no inverter on the output path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b0;
      high_q <= 1'b1;
    end else begin
      low_q  <= ~nxt_asserted;
      high_q <= nxt_asserted;
    end
  end

  assign rst_no = low_q;
  assign rst_o  = high_q;

  // R8
  pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_no);

  // R4
  hold_until_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !rst_no);
endmodule

// File: rtl/sup_reset_pulse_gen.sv
module sup_reset_pulse_gen
  import sup_rst_pkg::*;
#(
  parameter int STRETCH_TICKS = 200,
  parameter int SYNC_STAGES   = 2,
  localparam int CNT_W = $clog2(STRETCH_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic man_rst_ni,
  output logic rst_no,
  output logic rst_o
);
  logic             man_sync;
  rst_req_t         req;
  logic             reload;
  logic             cnt_done;
  logic [CNT_W-1:0] cnt;

  sup_rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (man_rst_ni),
    .q_o   (man_sync)
  );

  assign req.supply_low = supply_low_i;
  assign req.man_low    = ~man_sync;
  assign reload         = any_req(req);

  sup_rst_stretch #(.TICKS(STRETCH_TICKS)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .reload_i(reload),
    .done_o  (cnt_done),
    .cnt_o   (cnt)
  );

  sup_rst_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload),
    .done_i  (cnt_done),
    .rst_no  (rst_no),
    .rst_o   (rst_o)
  );

  // R3
  supply_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |=> !rst_no);

  // R5
  man_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !man_sync |=> !rst_no);

  // R4
  release_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(cnt == '0));
endmodule

// File: tb/sup_reset_pulse_gen_test.sv
`timescale 1ns/1ps
module sup_reset_pulse_gen_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tick_en = 1'b0;
  logic sup_low = 1'b0;
  logic man_n = 1'b1;
  logic rst_no, rst_o;

  int checks = 0;
  int fails = 0;
  bit model_on = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sup_reset_pulse_gen #(.STRETCH_TICKS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_low_i(sup_low),
    .man_rst_ni(man_n), .rst_no(rst_no), .rst_o(rst_o)
  );

  always @(negedge clk) tick <= tick_en ? ~tick : 1'b0;

  // behavioural reference
  bit mq[$];
  int rem;
  bit exp_asserted;
  bit trig;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = {1'b1, 1'b1};
      rem = N;
      exp_asserted = 1'b1;
    end else begin
      trig = sup_low || !mq[0];
      mq.push_back(man_n);
      void'(mq.pop_front());
      if (trig) begin
        rem = N;
        exp_asserted = 1'b1;
      end else if (rem == 0) exp_asserted = 1'b0;
      else if (tick) rem--;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on && !done) begin
    chk(rst_no === !exp_asserted, "R3/R4/R6 model", rst_no, !exp_asserted);
    chk(rst_o === ~rst_no, "R8 complement", rst_o, !rst_no);
  end

  task automatic measure(output int t, output bit ok);
    t = 0; ok = 0;
    repeat (20 * N) begin
      @(posedge clk);
      if (tick) t++;
      @(negedge clk);
      if (rst_no) begin ok = 1; break; end
    end
  endtask

  task automatic chk_stretch(string req, int lo, int hi);
    int t; bit ok;
    measure(t, ok);
    chk(ok && t >= lo && t <= hi, req, t, lo);
  endtask

  initial begin
    int lat;
    bit escaped;
    repeat (3) @(negedge clk);
    // R1
    chk(rst_no === 1'b0 && rst_o === 1'b1, "R1 reset state", rst_no, 0);
    model_on = 1;
    tick_en = 1;
    rst_n = 1;
    // R2
    chk_stretch("R2 power-up stretch", N, N + 1);
    repeat (4) @(negedge clk);

    // R3
    sup_low = 1;
    @(negedge clk);
    chk(rst_no === 1'b0, "R3 supply assert", rst_no, 0);
    repeat (3 * N) @(negedge clk);
    chk(rst_no === 1'b0, "R3 supply hold", rst_no, 0);
    // R4
    sup_low = 0;
    chk_stretch("R4 supply release", N, N + 1);
    repeat (3) @(negedge clk);

    // R5
    man_n = 0; lat = 0;
    repeat (10) begin
      @(negedge clk); lat++;
      if (!rst_no) break;
    end
    chk(lat == 3, "R5 manual latency", lat, 3);
    repeat (4) @(negedge clk);
    // R6
    man_n = 1;
    chk_stretch("R6 manual release", N, N + 2);
    repeat (3) @(negedge clk);

    // R7 bounce during stretch
    man_n = 0; repeat (4) @(negedge clk);
    man_n = 1; escaped = 0;
    repeat (N) begin @(negedge clk); if (rst_no) escaped = 1; end
    man_n = 0; @(negedge clk);
    man_n = 1;
    repeat (N + 4) begin @(negedge clk); if (rst_no) escaped = 1; end
    man_n = 0; repeat (2) @(negedge clk);
    man_n = 1;
    repeat (3) begin @(negedge clk); if (rst_no) escaped = 1; end
    chk(!escaped, "R7 no release pulse", escaped, 0);
    chk_stretch("R7 restart after bounce", N - 2, N);
    repeat (3) @(negedge clk);

    // R9 tick frozen
    sup_low = 1; repeat (2) @(negedge clk);
    sup_low = 0; tick_en = 0;
    repeat (4 * N) @(negedge clk);
    chk(rst_no === 1'b0, "R9 frozen without ticks", rst_no, 0);
    tick_en = 1;
    chk_stretch("R9 resume", N, N + 1);
    repeat (3) @(negedge clk);

    // R10 overlap
    man_n = 0; sup_low = 1; repeat (5) @(negedge clk);
    sup_low = 0;
    repeat (4 * N) @(negedge clk);
    chk(rst_no === 1'b0, "R10 held by manual", rst_no, 0);
    man_n = 1;
    chk_stretch("R10 release after both", N, N + 2);
    man_n = 0; repeat (3) @(negedge clk);
    sup_low = 1; man_n = 1;
    repeat (4 * N) @(negedge clk);
    chk(rst_no === 1'b0, "R10 held by supply", rst_no, 0);
    sup_low = 0;
    chk_stretch("R10 supply last", N, N + 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule